// File: doc/BRIEF.md
# Memory Bus Complement Stress Generator

This block exercises a RAM bus under the worst simultaneous switching it can produce. It does not try to cover the array. It cycles through three fixed address pairs, and in each pair the two addresses differ in as many lines as possible. It writes complementary data to the two addresses of a pair, reads both locations back, and then repeats the pair with zeros. Every access follows the previous one on the next cycle, so the address and data lines swing in a block from cycle to cycle. The point is to provoke noise, crosstalk and timing failures in the board-level memory path rather than to find weak cells.

A run starts with a start pulse and an iteration count. A count of zero runs until stop is raised. The data polarity flips on each iteration, so every line toggles in both directions over two iterations. Each read is compared against the value that was written, allowing one cycle of read latency. The first mismatch is captured together with its address, the expected word and the observed word, and a sticky fail flag is set. A finite run ends with a single-cycle done pulse.

Top module: `mbs_stress_gen`

## Requirements
- R1: After synchronous reset, busy, done, fail, mem_we and mem_re are 0, and mem_addr, fail_addr, fail_exp and fail_obs are all zero.
- R2: Address pairs are used in a fixed, repeating order of (first, second): (0x0000, 0xFFFF), then (0x00FF, 0x0100), then (0x5555, 0xAAAA). For other widths these are: all-zeros and all-ones; lower-half-ones and that value plus one; alternating bits with bit 0 set and their complement.
- R3: For each pair the generator issues 8 accesses in this order: write first, write second, read first, read second, first in the complement round and then again in the zero round. Exactly one of mem_we and mem_re is high per access.
- R4: In the complement round of an even iteration (counted from 0), the first address receives 0xFFFF, 0xFF00 and 0xAAAA for pairs 0, 1 and 2 respectively. Odd iterations use the bitwise inverse. The second address always receives the complement of the word written to the first.
- R5: In the zero round both addresses are written with all-zeros, and the read-back is expected to be all-zeros.
- R6: The first access appears on the bus two clock edges after start is sampled. From then until the run ends, every cycle carries an access, with no idle cycles.
- R7: With an iteration count N > 0, the run issues exactly 24·N accesses. busy then drops, and done pulses high for one cycle, two edges after the cycle that carries the final read.
- R8: With an iteration count of 0, the run continues across iterations until stop is sampled high. From the next edge on, no further access is issued, and no done pulse follows.
- R9: Read data is sampled on mem_rdata one cycle after the read is presented. A memory that returns the written data never sets fail.
- R10: The first read whose data differs from the expected word sets fail and latches fail_addr, fail_exp and fail_obs. Later mismatches do not change them until the next accepted start.
- R11: A start accepted while idle clears fail and the captured values, visible one edge later. A start raised while busy is ignored, and the access sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run when idle |
| stop | input | 1 | End a run before the next access |
| iter_count | input | IW | Iterations to run; 0 means run until stop |
| mem_addr | output | AW | RAM address |
| mem_wdata | output | DW | RAM write data (expected data on reads) |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_rdata | input | DW | RAM read data, one cycle after mem_re |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a finite run |
| fail | output | 1 | Sticky mismatch flag |
| fail_addr | output | AW | Address of the first failing read |
| fail_exp | output | DW | Expected word of the first failing read |
| fail_obs | output | DW | Observed word of the first failing read |

## Verification
A corrupted step counter shows up on the very next access as the wrong address, the wrong strobe or the wrong data word, and the bus trace is compared against an independent model on every cycle. A wrong polarity bit only shows once the second iteration begins, so runs of two or three iterations and a long endless run are included. An off-by-one in the read pipeline shows as a false fail, or as a wrong fail_obs, by the end of the same run. Iteration or stop errors show as an access count, a done timing or a bus-quiet cycle that differs from the expected one by a single cycle.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  localparam int NUM_PAIRS = 3;
  localparam int PAIR_W    = 2;
  localparam int OPS_PER_ROUND = 4;

  typedef enum logic [1:0] {
    OP_WR_A = 2'd0,
    OP_WR_B = 2'd1,
    OP_RD_A = 2'd2,
    OP_RD_B = 2'd3
  } op_e;

  typedef enum logic {
    RND_CMPL = 1'b0,
    RND_ZERO = 1'b1
  } round_e;

  typedef struct packed {
    logic [PAIR_W-1:0] pair;
    round_e            rnd;
    op_e               op;
  } step_t;
endpackage

// File: rtl/mbs_sequencer.sv
module mbs_sequencer
  import mbs_pkg::*;
#(
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          stop,
  input  logic [IW-1:0] iter_count,
  output logic          run,
  output logic          issue,
  output logic          last,
  output logic          swap,
  output step_t         step
);
  localparam logic [PAIR_W-1:0] LAST_PAIR = PAIR_W'(NUM_PAIRS - 1);

  logic [IW-1:0] remain_q;
  logic          endless_q;
  logic          iter_end;

  always_comb begin
    iter_end = (step.pair == LAST_PAIR) && (step.rnd == RND_ZERO) && (step.op == OP_RD_B);
    issue    = run & ~stop;
    last     = issue & iter_end & ~endless_q & (remain_q == IW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run       <= 1'b0;
      step      <= '0;
      swap      <= 1'b0;
      remain_q  <= '0;
      endless_q <= 1'b0;
    end else if (!run) begin
      if (start) begin
        run       <= 1'b1;
        step      <= '0;
        swap      <= 1'b0;
        remain_q  <= iter_count;
        endless_q <= (iter_count == '0);
      end
    end else if (stop) begin
      run <= 1'b0;
    end else begin
      step.op <= op_e'(step.op + 2'd1);
      if (step.op == OP_RD_B) begin
        if (step.rnd == RND_CMPL) begin
          step.rnd <= RND_ZERO;
        end else begin
          step.rnd <= RND_CMPL;
          if (step.pair == LAST_PAIR) begin
            step.pair <= '0;
            swap      <= ~swap;
            if (!endless_q) remain_q <= remain_q - IW'(1);
            if (last) run <= 1'b0;
          end else begin
            step.pair <= step.pair + PAIR_W'(1);
          end
        end
      end
    end
  end

  // R2
  pair_range_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (step.pair <= LAST_PAIR));

  // R8
  stop_halts_chk: assert property (@(posedge clk) disable iff (rst)
    (run && stop) |=> !run);

  // R11
  keeps_running_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !stop && !last) |=> run);

  // R7
  finite_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !endless_q) |-> (remain_q != '0));
endmodule

// File: rtl/mbs_pattern.sv
module mbs_pattern
  import mbs_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  step_t          step,
  input  logic           swap,
  output logic [AW-1:0]  addr,
  output logic [DW-1:0]  data,
  output logic           is_wr
);
  function automatic logic [AW-1:0] alt_addr();
    logic [AW-1:0] r;
    for (int i = 0; i < AW; i++) r[i] = (i % 2 == 0);
    return r;
  endfunction

  function automatic logic [DW-1:0] alt_data();
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++) r[i] = (i % 2 == 0);
    return r;
  endfunction

  localparam logic [AW-1:0] LO_A  = {{(AW - AW/2){1'b0}}, {(AW/2){1'b1}}};
  localparam logic [AW-1:0] HI1_A = LO_A + AW'(1);
  localparam logic [AW-1:0] ALT_A = alt_addr();
  localparam logic [DW-1:0] LO_D  = {{(DW - DW/2){1'b0}}, {(DW/2){1'b1}}};
  localparam logic [DW-1:0] ALT_D = alt_data();

  logic [AW-1:0] a_first, a_second;
  logic [DW-1:0] pat, base;
  logic          sel_second;

  always_comb begin
    case (step.pair)
      PAIR_W'(1): begin a_first = LO_A;  a_second = HI1_A;  pat = ~LO_D;  end
      PAIR_W'(2): begin a_first = ALT_A; a_second = ~ALT_A; pat = ~ALT_D; end
      default:    begin a_first = '0;    a_second = '1;     pat = '1;     end
    endcase
    base       = swap ? ~pat : pat;
    sel_second = (step.op == OP_WR_B) || (step.op == OP_RD_B);
    is_wr      = (step.op == OP_WR_A) || (step.op == OP_WR_B);
    addr       = sel_second ? a_second : a_first;
    if (step.rnd == RND_ZERO) data = '0;
    else                      data = sel_second ? ~base : base;
  end
endmodule

// File: rtl/mbs_checker.sv
module mbs_checker #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          rd_v,
  input  logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_exp,
  input  logic          rd_last,
  input  logic [DW-1:0] rdata,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] fail_addr,
  output logic [DW-1:0] fail_exp,
  output logic [DW-1:0] fail_obs
);
  logic          v_q, last_q;
  logic [AW-1:0] a_q;
  logic [DW-1:0] e_q;
  logic          mismatch;

  assign mismatch = v_q && (rdata != e_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q       <= 1'b0;
      last_q    <= 1'b0;
      a_q       <= '0;
      e_q       <= '0;
      done      <= 1'b0;
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_exp  <= '0;
      fail_obs  <= '0;
    end else begin
      v_q    <= rd_v & ~clr;
      last_q <= rd_last & ~clr;
      a_q    <= rd_addr;
      e_q    <= rd_exp;
      done   <= last_q & ~clr;
      if (clr) begin
        fail      <= 1'b0;
        fail_addr <= '0;
        fail_exp  <= '0;
        fail_obs  <= '0;
      end else if (mismatch && !fail) begin
        fail      <= 1'b1;
        fail_addr <= a_q;
        fail_exp  <= e_q;
        fail_obs  <= rdata;
      end
    end
  end

  // R10
  fail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (fail && !clr) |=> fail);

  // R10
  capture_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fail && !clr) |=> ($stable(fail_addr) && $stable(fail_exp) && $stable(fail_obs)));

  // R10
  capture_differs_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fail) |-> (fail_obs != fail_exp));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/mbs_stress_gen.sv
module mbs_stress_gen
  import mbs_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          stop,
  input  logic [IW-1:0] iter_count,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] fail_addr,
  output logic [DW-1:0] fail_exp,
  output logic [DW-1:0] fail_obs
);
  logic          run, issue, last, swap, clr, last_bus, is_wr;
  step_t         step;
  logic [AW-1:0] nxt_addr;
  logic [DW-1:0] nxt_data;

  assign clr  = start & ~run;
  assign busy = run;

  mbs_sequencer #(.IW(IW)) u_seq (
    .clk(clk), .rst(rst), .start(start), .stop(stop), .iter_count(iter_count),
    .run(run), .issue(issue), .last(last), .swap(swap), .step(step)
  );

  mbs_pattern #(.AW(AW), .DW(DW)) u_pat (
    .step(step), .swap(swap), .addr(nxt_addr), .data(nxt_data), .is_wr(is_wr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      last_bus  <= 1'b0;
    end else begin
      mem_we   <= issue & is_wr;
      mem_re   <= issue & ~is_wr;
      last_bus <= last;
      if (issue) begin
        mem_addr  <= nxt_addr;
        mem_wdata <= nxt_data;
      end
    end
  end

  mbs_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst(rst), .clr(clr),
    .rd_v(mem_re), .rd_addr(mem_addr), .rd_exp(mem_wdata), .rd_last(last_bus),
    .rdata(mem_rdata),
    .done(done), .fail(fail), .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_obs(fail_obs)
  );

  // R6
  no_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !stop) |=> (mem_we || mem_re));

  // R3
  one_access_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_we, mem_re}));
endmodule

// File: tb/test_mbs_stress_gen.sv
module test_mbs_stress_gen;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int IW = 16;
  localparam int WD_LIMIT = 20000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          stop = 1'b0;
  logic [IW-1:0] iter_count = '0;
  logic [AW-1:0] mem_addr, fail_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, fail_exp, fail_obs;
  logic          mem_we, mem_re, busy, done, fail;

  always #2 clk = ~clk;

  mbs_stress_gen #(.AW(AW), .DW(DW), .IW(IW)) i_mbs_stress_gen (
    .clk(clk), .rst(rst), .start(start), .stop(stop), .iter_count(iter_count),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .fail(fail),
    .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_obs(fail_obs)
  );

  int total = 0, bad = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // reference model of the access trace
  function automatic logic [AW-1:0] ref_addr(int pair, int second);
    case (pair)
      0:       return (second != 0) ? 16'hFFFF : 16'h0000;
      1:       return (second != 0) ? 16'h0100 : 16'h00FF;
      default: return (second != 0) ? 16'hAAAA : 16'h5555;
    endcase
  endfunction

  function automatic bit ref_wr(int k);
    return (k % 4) < 2;
  endfunction

  function automatic logic [AW-1:0] ref_addr_k(int k);
    return ref_addr(k / 8, (k % 4) % 2);
  endfunction

  function automatic logic [DW-1:0] ref_data(int k, int it);
    logic [DW-1:0] b;
    if (((k / 4) % 2) == 1) return '0;
    case (k / 8)
      0:       b = 16'hFFFF;
      1:       b = 16'hFF00;
      default: b = 16'hAAAA;
    endcase
    if ((it % 2) == 1) b = ~b;
    return (((k % 4) % 2) == 1) ? ~b : b;
  endfunction

  // memory with optional read corruption
  logic [DW-1:0] mem_model [logic [AW-1:0]];
  logic          flt_en = 1'b0;
  logic [AW-1:0] flt_addr = '0;
  logic [DW-1:0] flt_mask = '0;

  always @(posedge clk) begin
    if (mem_we) mem_model[mem_addr] = mem_wdata;
    if (mem_re)
      mem_rdata <= (mem_model.exists(mem_addr) ? mem_model[mem_addr] : '0)
                   ^ ((flt_en && mem_addr == flt_addr) ? flt_mask : '0);
  end

  // watchdog
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WD_LIMIT);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // bus monitor
  int acc_cnt = 0, first_cyc = 0, last_cyc = 0, gaps = 0, done_cnt = 0, done_cyc = 0;

  always @(negedge clk) begin : mon
    int k, it;
    if (!rst) begin
      if (mem_we || mem_re) begin
        k  = acc_cnt % 24;
        it = acc_cnt / 24;
        chk(mem_addr == ref_addr_k(k), "R2 address order", mem_addr, ref_addr_k(k));
        chk({mem_we, mem_re} == (ref_wr(k) ? 2'b10 : 2'b01), "R3 access kind",
            {mem_we, mem_re}, ref_wr(k) ? 2'b10 : 2'b01);
        if (mem_we)
          chk(mem_wdata == ref_data(k, it), ((k / 4) % 2 == 1) ? "R5 zero round data" : "R4 complement data",
              mem_wdata, ref_data(k, it));
        if (acc_cnt > 0 && cyc != last_cyc + 1) gaps++;
        if (acc_cnt == 0) first_cyc = cyc;
        last_cyc = cyc;
        acc_cnt++;
      end
      if (done) begin
        done_cnt++;
        done_cyc = cyc;
      end
    end
  end

  task automatic run_finite(input int n, input bit inj, input logic [AW-1:0] fa,
                            input logic [DW-1:0] fm, input int restart_at);
    int sc;
    logic [DW-1:0] fexp;
    fexp = '0;
    for (int k = 23; k >= 0; k--)
      if (!ref_wr(k) && ref_addr_k(k) == fa) fexp = ref_data(k, 0);
    flt_en = inj; flt_addr = fa; flt_mask = fm;
    @(negedge clk);
    acc_cnt = 0; gaps = 0; done_cnt = 0;
    iter_count = n[IW-1:0];
    start = 1'b1;
    sc = cyc;
    @(negedge clk);
    start = 1'b0;
    chk(fail == 1'b0 && fail_addr == '0, "R11 start clears capture", {fail, fail_addr}, 0);
    if (restart_at > 0) begin
      repeat (restart_at) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (done_cnt == 0 && cyc < WD_LIMIT) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(acc_cnt == 24 * n, (restart_at > 0) ? "R11 start while busy ignored" : "R7 access count",
        acc_cnt, 24 * n);
    chk(gaps == 0, "R6 no idle cycles", gaps, 0);
    chk(first_cyc == sc + 2, "R6 first access latency", first_cyc - sc, 2);
    chk(done_cnt == 1, "R7 single done pulse", done_cnt, 1);
    chk(done_cyc == last_cyc + 2, "R7 done timing", done_cyc - last_cyc, 2);
    chk(busy == 1'b0, "R7 busy cleared", busy, 0);
    chk(fail == inj, inj ? "R10 fail flag" : "R9 clean readback", fail, inj);
    if (inj) begin
      chk(fail_addr == fa, "R10 fail address", fail_addr, fa);
      chk(fail_exp == fexp, "R10 fail expected", fail_exp, fexp);
      chk(fail_obs == (fexp ^ fm), "R10 fail observed", fail_obs, fexp ^ fm);
    end
    flt_en = 1'b0;
  endtask

  task automatic run_endless(input int w);
    int sc, s;
    flt_en = 1'b0;
    @(negedge clk);
    acc_cnt = 0; gaps = 0; done_cnt = 0;
    iter_count = '0;
    start = 1'b1;
    sc = cyc;
    @(negedge clk);
    start = 1'b0;
    repeat (w) @(negedge clk);
    stop = 1'b1;
    s = cyc;
    @(negedge clk);
    stop = 1'b0;
    repeat (5) @(negedge clk);
    chk(last_cyc == s, "R8 bus quiet after stop", last_cyc, s);
    chk(acc_cnt == s - sc - 1, "R8 endless access count", acc_cnt, s - sc - 1);
    chk(acc_cnt > 48, "R8 ran past count", acc_cnt, 49);
    chk(done_cnt == 0, "R8 no done after stop", done_cnt, 0);
    chk(busy == 1'b0, "R8 busy cleared", busy, 0);
    chk(gaps == 0, "R6 no idle cycles endless", gaps, 0);
    chk(fail == 1'b0, "R9 clean readback endless", fail, 0);
  endtask

  initial begin
    int n, inj;
    logic [AW-1:0] fa;
    logic [DW-1:0] fm;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({busy, done, fail, mem_we, mem_re} == 5'b0, "R1 reset flags",
        {busy, done, fail, mem_we, mem_re}, 0);
    chk(mem_addr == '0 && fail_addr == '0 && fail_exp == '0 && fail_obs == '0,
        "R1 reset values", {fail_exp, fail_obs}, 0);

    run_finite(1, 1'b0, '0, '0, 0);
    run_finite(2, 1'b0, '0, '0, 10);
    run_finite(1, 1'b1, 16'hAAAA, 16'h0001, 0);
    run_finite(3, 1'b1, 16'h0000, 16'h8000, 0);
    run_finite(1, 1'b0, '0, '0, 0);
    run_endless(61);

    for (int i = 0; i < 6; i++) begin
      n   = 1 + int'($urandom % 3);
      inj = int'($urandom % 2);
      fa  = ref_addr(int'($urandom % 3), int'($urandom % 2));
      fm  = DW'(($urandom % 65535) + 1);
      run_finite(n, inj[0], fa, fm, 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule